// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This unit shifts a destination word left or right by a count and fills the vacated positions from the adjacent end of a second source word. The source is only read. Chained calls of the unit move bit fields between words, so they build multi-word shifts. The same chaining packs several small values into one word.

Operands are 16 or 32 bits wide. The unit computes the new destination value and a fresh set of status flags. It also computes a write-enable vector that tells the register file which flags to update. The update rules depend on the count.

One request is accepted per clock while `valid_i` is high. Results appear one cycle later.

Top module: `fsh_unit`

## Requirements
- R1: With `dir_i`=0 (left), the destination shifts up by the effective count k. Result bits k-1..0 take source bits W-1..W-k, where W is the operand width.
- R2: With `dir_i`=1 (right), the destination shifts down by k. Result bits W-1..W-k take source bits k-1..0.
- R3: With `size_i`=0 the operation works on bits 15..0 only. `result_o[31:16]` equals `dst_i[31:16]`, and source bits 31..16 have no effect.
- R4: The effective count k is `cnt_i[4:0]`. When k is 0, or k is not below W, the result equals `dst_i`, `flag_we_o` is 0 and `flags_o` equals `flags_i`.
- R5: For a valid nonzero k, the carry flag (bit 0) is written with the last bit shifted out. For the left form this is destination bit W-k. For the right form it is destination bit k-1.
- R6: For a valid nonzero k, the flags at bits 1, 2 and 3 are written from the W-bit result:
  - parity (bit 1) is 1 when result bits 7..0 hold an even number of ones;
  - zero (bit 2) is 1 when the result is all zeros;
  - sign (bit 3) is result bit W-1.
- R7: The overflow flag (bit 4) is written only when k=1, with the XOR of the old and new bit W-1. For any other k it is not written, and `flags_o[4]` equals `flags_i[4]`.
- R8: `valid_o` is high in the cycle after each cycle with `valid_i` high and low otherwise. All data outputs hold their values while no request arrives.
- R9: While `rst_ni` is low, `valid_o`, `result_o`, `flags_o` and `flag_we_o` are all zero.
- R10: Three chained 16-bit right shifts by 7, 5 and 4 pack a value Y (0..99), a value D (1..31) and a value M (1..12), each taken from the source. The final result is {M[3:0], D[4:0], Y[6:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| dir_i | input | 1 | 0 = left, 1 = right |
| size_i | input | 1 | 0 = 16-bit, 1 = 32-bit |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Fill source operand (read only) |
| cnt_i | input | 8 | Shift count; only bits 4..0 are used |
| flags_i | input | 5 | Current flags {of, sf, zf, pf, cf} |
| valid_o | output | 1 | Result strobe |
| result_o | output | 32 | New destination value |
| flags_o | output | 5 | Flags after the operation |
| flag_we_o | output | 5 | Per-flag write enables, same bit order |

## Verification
The hardest case to reach is a count whose low five bits are at or above 16 while the operand is 16 bits wide. The raw count can also carry high bits that masking must discard. Ordinary small counts never reach either case.

The stimulus targets these directly with counts of 16, 31 and 0x21. The random phase draws the full 8-bit count, so masked values above the width appear often. A chained packing sequence feeds each result back as the next destination, which exercises multi-step field insertion.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CNT_IN_W = 8;
  localparam int unsigned FLAG_W   = 5;

  typedef enum logic { DIR_LEFT = 1'b0, DIR_RIGHT = 1'b1 } fsh_dir_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic pf;
    logic cf;
  } fsh_flags_t;

  function automatic logic even_par8(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/fsh_count_ctl.sv
module fsh_count_ctl #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_IN_W = 8,
  localparam int unsigned CNT_W   = $clog2(DATA_W),
  localparam int unsigned HALF_W  = DATA_W / 2
) (
  input  logic [CNT_IN_W-1:0] cnt_i,
  input  logic                size_i,
  output logic [CNT_W-1:0]    amt_o,
  output logic                active_o,
  output logic                one_o
);
  logic in_range;

  assign amt_o    = cnt_i[CNT_W-1:0];
  // full width accepts every masked value; half width only below HALF_W
  assign in_range = size_i ? 1'b1 : (32'(amt_o) < HALF_W);
  assign active_o = (amt_o != '0) && in_range;
  assign one_o    = (amt_o == CNT_W'(1));
endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = 5,
  localparam int unsigned EXT_W = 2 * W + 1
) (
  input  logic             dir_i,
  input  logic [W-1:0]     dst_i,
  input  logic [W-1:0]     src_i,
  input  logic [CNT_W-1:0] amt_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);
  import fsh_pkg::*;

  logic [EXT_W-1:0] ext_l, ext_r, shf_l, shf_r;

  // one guard bit beyond the destination catches the last bit out
  assign ext_l = {1'b0, dst_i, src_i};
  assign ext_r = {src_i, dst_i, 1'b0};
  assign shf_l = ext_l << amt_i;
  assign shf_r = ext_r >> amt_i;

  always_comb begin
    if (fsh_dir_e'(dir_i) == DIR_LEFT) begin
      res_o   = shf_l[2*W-1:W];
      carry_o = shf_l[2*W];
    end else begin
      res_o   = shf_r[W:1];
      carry_o = shf_r[0];
    end
  end
endmodule

// File: rtl/fsh_flag_gen.sv
module fsh_flag_gen #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic              size_i,
  input  logic              active_i,
  input  logic              one_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              carry_i,
  input  logic [4:0]        flags_i,
  output logic [4:0]        flags_o,
  output logic [4:0]        we_o
);
  import fsh_pkg::*;

  fsh_flags_t fin, fnew, wen;
  logic msb_new, msb_old, zero;

  assign fin     = fsh_flags_t'(flags_i);
  assign msb_new = size_i ? res_i[DATA_W-1] : res_i[HALF_W-1];
  assign msb_old = size_i ? dst_i[DATA_W-1] : dst_i[HALF_W-1];
  assign zero    = size_i ? (res_i == '0) : (res_i[HALF_W-1:0] == '0);

  always_comb begin
    wen = '0;
    if (active_i) begin
      wen.cf = 1'b1;
      wen.pf = 1'b1;
      wen.zf = 1'b1;
      wen.sf = 1'b1;
      wen.of = one_i;
    end
  end

  always_comb begin
    fnew    = fin;
    fnew.cf = wen.cf ? carry_i           : fin.cf;
    fnew.pf = wen.pf ? even_par8(res_i[7:0]) : fin.pf;
    fnew.zf = wen.zf ? zero              : fin.zf;
    fnew.sf = wen.sf ? msb_new           : fin.sf;
    fnew.of = wen.of ? (msb_old ^ msb_new) : fin.of;
  end

  assign flags_o = fnew;
  assign we_o    = wen;
endmodule

// File: rtl/fsh_unit.sv
module fsh_unit #(
  parameter int unsigned DATA_W   = fsh_pkg::DATA_W,
  parameter int unsigned CNT_IN_W = fsh_pkg::CNT_IN_W,
  localparam int unsigned CNT_W   = $clog2(DATA_W),
  localparam int unsigned HALF_W  = DATA_W / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                dir_i,
  input  logic                size_i,
  input  logic [DATA_W-1:0]   dst_i,
  input  logic [DATA_W-1:0]   src_i,
  input  logic [CNT_IN_W-1:0] cnt_i,
  input  logic [4:0]          flags_i,
  output logic                valid_o,
  output logic [DATA_W-1:0]   result_o,
  output logic [4:0]          flags_o,
  output logic [4:0]          flag_we_o
);
  logic [CNT_W-1:0]  amt;
  logic              active, one;
  logic [DATA_W-1:0] lane_res [2];
  logic              lane_cy  [2];
  logic [DATA_W-1:0] sel_res, core_res;
  logic              sel_cy;
  logic [4:0]        nxt_flags, nxt_we;

  fsh_count_ctl #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) u_cnt (
    .cnt_i   (cnt_i),
    .size_i  (size_i),
    .amt_o   (amt),
    .active_o(active),
    .one_o   (one)
  );

  // lane 0 = half width, lane 1 = full width
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int unsigned LW = HALF_W << g;
    logic [LW-1:0] r;
    logic          c;
    fsh_funnel #(.W(LW), .CNT_W(CNT_W)) u_fun (
      .dir_i  (dir_i),
      .dst_i  (dst_i[LW-1:0]),
      .src_i  (src_i[LW-1:0]),
      .amt_i  (amt),
      .res_o  (r),
      .carry_o(c)
    );
    assign lane_res[g] = DATA_W'(r);
    assign lane_cy[g]  = c;
  end

  always_comb begin
    if (size_i) begin
      sel_res = lane_res[1];
      sel_cy  = lane_cy[1];
    end else begin
      sel_res = {dst_i[DATA_W-1:HALF_W], lane_res[0][HALF_W-1:0]};
      sel_cy  = lane_cy[0];
    end
    core_res = active ? sel_res : dst_i;
  end

  fsh_flag_gen #(.DATA_W(DATA_W)) u_flg (
    .size_i  (size_i),
    .active_i(active),
    .one_i   (one),
    .res_i   (core_res),
    .dst_i   (dst_i),
    .carry_i (sel_cy),
    .flags_i (flags_i),
    .flags_o (nxt_flags),
    .we_o    (nxt_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      flags_o   <= '0;
      flag_we_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= core_res;
        flags_o   <= nxt_flags;
        flag_we_o <= nxt_we;
      end
    end
  end
endmodule

// File: rtl/fsh_unit_chk.sv
module fsh_unit_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_IN_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                dir_i,
  input logic                size_i,
  input logic [DATA_W-1:0]   dst_i,
  input logic [DATA_W-1:0]   src_i,
  input logic [CNT_IN_W-1:0] cnt_i,
  input logic [4:0]          flags_i,
  input logic                valid_o,
  input logic [DATA_W-1:0]   result_o,
  input logic [4:0]          flags_o,
  input logic [4:0]          flag_we_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  assert_valid_pipe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(result_o) && $stable(flags_o) && $stable(flag_we_o));
  assert_zero_cnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cnt_i[4:0] == 5'd0 |=> result_o == $past(dst_i) && flag_we_o == 5'd0
      && flags_o == $past(flags_i));
  assert_upper_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !size_i |=> result_o[DATA_W-1:HALF_W] == $past(dst_i[DATA_W-1:HALF_W]));
  assert_of_only_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cnt_i[4:0] != 5'd1 |=> !flag_we_o[4] && flags_o[4] == $past(flags_i[4]));
  assert_we_group_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> flag_we_o[3:0] == 4'h0 || flag_we_o[3:0] == 4'hF);
  assert_zf_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flag_we_o[2] |-> flags_o[2] ==
      ($past(size_i) ? (result_o == '0) : (result_o[HALF_W-1:0] == '0)));
endmodule

bind fsh_unit fsh_unit_chk #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) u_chk (.*);

// File: tb/tb_fsh_unit.sv
`timescale 1ns/1ps
module tb_fsh_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, dir_i = 1'b0, size_i = 1'b0;
  logic [31:0] dst_i = '0, src_i = '0;
  logic [7:0]  cnt_i = '0;
  logic [4:0]  flags_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [4:0]  flags_o, flag_we_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsh_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .dir_i(dir_i), .size_i(size_i),
    .dst_i(dst_i), .src_i(src_i), .cnt_i(cnt_i), .flags_i(flags_i),
    .valid_o(valid_o), .result_o(result_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
  );

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-serial reference: one position per step
  function automatic void ref_op(input logic d, input logic s, input logic [31:0] dst,
                                 input logic [31:0] src, input logic [7:0] cnt,
                                 input logic [4:0] fin, output logic [31:0] res,
                                 output logic [4:0] fo, output logic [4:0] we);
    int w = s ? 32 : 16;
    int m = int'(cnt) % 32;
    logic [31:0] mask = s ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] v = dst & mask;
    logic [31:0] sv = src & mask;
    logic c = 1'b0;
    if (m == 0 || m >= w) begin
      res = dst; fo = fin; we = 5'd0;
      return;
    end
    for (int i = 0; i < m; i++) begin
      if (!d) begin
        c = v[w-1];
        v = ((v << 1) | 32'(sv[w-1-i])) & mask;
      end else begin
        c = v[0];
        v = (v >> 1) | (32'(sv[i]) << (w - 1));
      end
    end
    res = s ? v : {dst[31:16], v[15:0]};
    fo[0] = c;
    fo[1] = ~(^v[7:0]);
    fo[2] = (v == 32'd0);
    fo[3] = v[w-1];
    fo[4] = (m == 1) ? (dst[w-1] ^ v[w-1]) : fin[4];
    we = (m == 1) ? 5'h1F : 5'h0F;
  endfunction

  // cycle model compared every clock
  logic        m_val = 0;
  logic [31:0] m_res = '0;
  logic [4:0]  m_fl = '0, m_we = '0;
  string       tag_res;
  logic        m_active, m_size;

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_val = 0; m_res = '0; m_fl = '0; m_we = '0;
    end else begin
      m_val = valid_i;
      if (valid_i) begin
        ref_op(dir_i, size_i, dst_i, src_i, cnt_i, flags_i, m_res, m_fl, m_we);
        m_size   = size_i;
        m_active = (m_we != 0);
        tag_res  = !m_active ? "R4" : (dir_i ? "R2" : "R1");
      end
    end
    #2;
    if (rst_n && !done) begin
      chk("R8 valid", 32'(valid_o), 32'(m_val));
      chk({tag_res, " result"}, result_o, m_res);
      if (!m_size) chk("R3 upper half", 32'(result_o[31:16]), 32'(m_res[31:16]));
      chk(m_active ? "R5 carry" : "R4 carry", 32'(flags_o[0]), 32'(m_fl[0]));
      chk(m_active ? "R6 pf/zf/sf" : "R4 pf/zf/sf", 32'(flags_o[3:1]), 32'(m_fl[3:1]));
      chk("R7 overflow", 32'(flags_o[4]), 32'(m_fl[4]));
      chk(m_active ? "R6 write enables" : "R4 write enables", 32'(flag_we_o), 32'(m_we));
    end
  end

  task automatic op(input logic d, s, input logic [31:0] dv, sv, input logic [7:0] c,
                    input logic [4:0] f);
    @(negedge clk);
    valid_i = 1; dir_i = d; size_i = s; dst_i = dv; src_i = sv; cnt_i = c; flags_i = f;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 0;
      dst_i = $urandom; src_i = $urandom; cnt_i = 8'($urandom);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pk;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 valid", 32'(valid_o), 32'd0);
    chk("R9 result", result_o, 32'd0);
    chk("R9 flags", 32'(flags_o), 32'd0);
    chk("R9 we", 32'(flag_we_o), 32'd0);
    rst_n = 1;
    // R1 / R2 directed
    op(0, 1, 32'h1234_5678, 32'hABCD_EF01, 8'd4, 5'h00);
    op(1, 1, 32'h1234_5678, 32'hABCD_EF01, 8'd8, 5'h1F);
    op(0, 0, 32'hDEAD_4000, 32'hFFFF_8000, 8'd1, 5'h00);  // R7 sign change
    op(1, 0, 32'hCAFE_0001, 32'h1234_FFFF, 8'd15, 5'h00);
    op(1, 1, 32'h0000_0001, 32'h0000_0000, 8'd1, 5'h00);  // zero result
    // R4 count corners
    op(0, 1, 32'h8000_0001, 32'h5555_5555, 8'd0, 5'h15);
    op(0, 0, 32'h0000_8001, 32'h5555_5555, 8'd16, 5'h0A);
    op(1, 0, 32'h0000_8001, 32'h5555_5555, 8'd31, 5'h11);
    op(1, 1, 32'h8000_0001, 32'h5555_5555, 8'h21, 5'h00);
    op(0, 1, 32'h8000_0001, 32'h7FFF_FFFF, 8'd31, 5'h00);
    op(1, 0, 32'h1111_2222, 32'hEEEE_0001, 8'hE0, 5'h1F);
    // R3 source upper bits unused
    op(0, 0, 32'h0000_00F0, 32'hFFFF_0000, 8'd4, 5'h00);
    idle(3);
    // R10 field packing via chaining
    op(1, 0, 32'h0000_0000, 32'd87, 8'd7, 5'h00);
    @(negedge clk); pk = result_o;
    valid_i = 1; dir_i = 1; size_i = 0; dst_i = pk; src_i = 32'd23; cnt_i = 8'd5;
    @(negedge clk); pk = result_o;
    valid_i = 1; dir_i = 1; size_i = 0; dst_i = pk; src_i = 32'd11; cnt_i = 8'd4;
    @(negedge clk);
    valid_i = 0;
    chk("R10 packed word", 32'(result_o[15:0]), 32'({4'd11, 5'd23, 7'd87}));
    idle(2);
    // random sweep
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 4) == 0) idle(1);
      else op(1'($urandom), 1'($urandom), $urandom, $urandom, 8'($urandom), 5'($urandom));
    end
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule